// File: doc/BRIEF.md
# Banked Shared-Cache Crossbar Arbiter

This block sits between a group of processors and the banks of one logically shared first-level cache. Every processor may present one request per cycle: a read or a write of one block. The block decodes which bank the address selects. It routes the request across an N-by-M crossbar, so requests to different banks proceed in the same cycle. When two or more requests land on the same bank, it picks one per bank per cycle.

Reads of the block that already won the bank are folded into that single bank read. The returned word is then handed to every one of those readers, and none of them stalls. Any other request that loses the bank sees its stall line high in the same cycle and must hold its request. Read data comes back one cycle after the grant. The bank count is a parameter and may exceed the processor count. The banks are simple synchronous memories outside this block: each takes an enable, a write flag, an index and write data, and returns read data on the next clock edge.

Top module: `xbar_bank_arb`

## Requirements
- R1: The bank number of a request is `addr[OFF_W +: BANK_W]`, where `BANK_W = log2(NUM_BANK)` and NUM_BANK is a power of two that may exceed NUM_PROC. The index sent to the bank is `addr[ADDR_W-1 : OFF_W+BANK_W]`. Consecutive blocks therefore fall in consecutive banks.
- R2: Valid requests that all target different banks in one cycle are all served in that cycle, and none of them stalls.
- R3: Each bank performs at most one access per cycle. Its `bank_en` is high in every cycle in which any valid request targets it. `req_stall[p]` is high exactly when request p is valid and not served; it is never high for an invalid request.
- R4: Among requests to one bank, the winner is the first requester at or after that bank's pointer, counting upward with wrap-around. After each cycle in which the bank is used, the pointer moves to the winner plus one, modulo NUM_PROC.
- R5: When the winner of a bank is a read, every other valid read to the same block is served in the same cycle. Two requests are to the same block when they are equal in `addr[ADDR_W-1:OFF_W]`. The bank sees a single read.
- R6: `resp_valid[p]` is high in the cycle after a served read of processor p, and `resp_data` slice p then holds the bank word at that index. A served write raises no `resp_valid`.
- R7: When the winner of a bank is a write, it is the only request served at that bank. Reads to the same block stall as well. The bank is written with that processor's data at the decoded index, and later reads return it.
- R8: While `rst` is high, `resp_valid` is low, and every bank pointer returns to processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PROC | Request present, one bit per processor |
| req_write | input | NUM_PROC | 1 = write, 0 = read |
| req_addr | input | NUM_PROC*ADDR_W | Request addresses, processor p at slice p |
| req_wdata | input | NUM_PROC*DATA_W | Write data, processor p at slice p |
| req_stall | output | NUM_PROC | Request not served this cycle, hold it |
| resp_valid | output | NUM_PROC | Read data present for processor p |
| resp_data | output | NUM_PROC*DATA_W | Read data, processor p at slice p |
| bank_en | output | NUM_BANK | Bank access this cycle |
| bank_we | output | NUM_BANK | Access is a write |
| bank_idx | output | NUM_BANK*(ADDR_W-OFF_W-log2(NUM_BANK)) | Word index inside the bank |
| bank_wdata | output | NUM_BANK*DATA_W | Data to write |
| bank_rdata | input | NUM_BANK*DATA_W | Bank read data, one cycle after a read enable |

## Verification
The assertions assume that every bank behaves as a one-cycle synchronous memory. They also assume that a processor presents exactly one request per cycle, and that the request sits stable before the clock edge. The stimulus drives all inputs half a period away from the rising edge. It pairs the block with bench-side memories of that exact latency, and draws its addresses from a few banks and a handful of indices. This crowds requests onto shared banks and shared blocks, so merges, write conflicts and pointer rotation all occur often.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

  // Advance a round-robin position by one, wrapping at the requester count.
  function automatic int unsigned wrap_next(input int unsigned pos, input int unsigned count);
    return (pos + 1 >= count) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode #(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W   = 12,
  parameter int OFF_W    = 2,
  parameter int BANK_W   = 3
) (
  input  logic [NUM_PROC-1:0][ADDR_W-1:0]       addr,
  output logic [NUM_PROC-1:0][BANK_W-1:0]       bank_sel,
  output logic [NUM_PROC-1:0][ADDR_W-OFF_W-1:0] blk_tag
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [NUM_PROC-1:0][OFF_W-1:0] unused_offset;
  logic                           unused_fold;

  generate
    for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      assign bank_sel[p]      = addr[p][OFF_W +: BANK_W];
      assign blk_tag[p]       = addr[p][OFF_W +: TAG_W];
      assign unused_offset[p] = addr[p][OFF_W-1:0];
    end
  endgenerate

  assign unused_fold = ^unused_offset;

endmodule

// File: rtl/xbar_bank_slice.sv
module xbar_bank_slice #(
  parameter int NUM_PROC = 4,
  parameter int BANK_W   = 3,
  parameter int TAG_W    = 10,
  parameter int DATA_W   = 32,
  parameter int BANK_ID  = 0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PROC-1:0]                 req_valid,
  input  logic [NUM_PROC-1:0]                 req_write,
  input  logic [NUM_PROC-1:0][BANK_W-1:0]     bank_sel,
  input  logic [NUM_PROC-1:0][TAG_W-1:0]      blk_tag,
  input  logic [NUM_PROC-1:0][DATA_W-1:0]     wdata,
  output logic [NUM_PROC-1:0]                 grant,
  output logic                                mem_en,
  output logic                                mem_we,
  output logic [TAG_W-BANK_W-1:0]             mem_idx,
  output logic [DATA_W-1:0]                   mem_wdata
);
  localparam int PTR_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [NUM_PROC-1:0] tgt;
  logic [PTR_W-1:0]    ptr_q;
  logic [PTR_W-1:0]    win;
  logic                found;
  logic                win_write;
  logic [TAG_W-1:0]    win_tag;

  generate
    for (genvar p = 0; p < NUM_PROC; p++) begin : g_tgt
      assign tgt[p] = req_valid[p] && (bank_sel[p] == MY_BANK);
    end
  endgenerate

  // Round-robin search starting at the pointer.
  always_comb begin
    int k;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NUM_PROC; i++) begin
      k = int'(ptr_q) + i;
      if (k >= NUM_PROC) k = k - NUM_PROC;
      if (!found && tgt[k]) begin
        found = 1'b1;
        win   = k[PTR_W-1:0];
      end
    end
  end

  assign win_write = req_write[win];
  assign win_tag   = blk_tag[win];

  // Winner plus every read of the same block when the winner reads.
  always_comb begin
    for (int p = 0; p < NUM_PROC; p++) begin
      grant[p] = found && tgt[p] &&
                 ((p == int'(win)) ||
                  (!win_write && !req_write[p] && (blk_tag[p] == win_tag)));
    end
  end

  assign mem_en    = found;
  assign mem_we    = found && win_write;
  assign mem_idx   = win_tag[TAG_W-1:BANK_W];
  assign mem_wdata = wdata[win];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= PTR_W'(xbar_arb_pkg::wrap_next(int'(win), NUM_PROC));
    end
  end

  AST_WRITE_ALONE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(grant) == 1)); // R7

  AST_GRANT_TARGETED: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~tgt) == '0)); // R3

  AST_BANK_SERVES: assert property (@(posedge clk) disable iff (rst)
    (tgt != '0) |-> (mem_en && (grant != '0))); // R3

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int p = 0; p < NUM_PROC; p++) begin
        for (int q = 0; q < NUM_PROC; q++) begin
          if (grant[p] && tgt[q] && !req_write[p] && !req_write[q] &&
              (blk_tag[p] == blk_tag[q])) begin
            AST_MERGE_ALL: assert (grant[q]); // R5
          end
        end
      end
    end
  end

endmodule

// File: rtl/xbar_resp_route.sv
module xbar_resp_route #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BANK = 8,
  parameter int BANK_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PROC-1:0]                 rd_served,
  input  logic [NUM_PROC-1:0][BANK_W-1:0]     bank_sel,
  input  logic [NUM_BANK-1:0][DATA_W-1:0]     bank_rdata,
  output logic [NUM_PROC-1:0]                 resp_valid,
  output logic [NUM_PROC-1:0][DATA_W-1:0]     resp_data
);
  logic [NUM_PROC-1:0][BANK_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= '0;
      sel_q      <= '0;
    end else begin
      resp_valid <= rd_served;
      sel_q      <= bank_sel;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PROC; p++) begin : g_out
      assign resp_data[p] = bank_rdata[sel_q[p]];
    end
  endgenerate

endmodule

// File: rtl/xbar_bank_arb.sv
module xbar_bank_arb #(
  parameter  int NUM_PROC = 4,
  parameter  int NUM_BANK = 8,
  parameter  int ADDR_W   = 12,
  parameter  int OFF_W    = 2,
  parameter  int DATA_W   = 32,
  localparam int BANK_W   = $clog2(NUM_BANK),
  localparam int TAG_W    = ADDR_W - OFF_W,
  localparam int IDX_W    = TAG_W - BANK_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PROC-1:0]          req_valid,
  input  logic [NUM_PROC-1:0]          req_write,
  input  logic [NUM_PROC*ADDR_W-1:0]   req_addr,
  input  logic [NUM_PROC*DATA_W-1:0]   req_wdata,
  output logic [NUM_PROC-1:0]          req_stall,
  output logic [NUM_PROC-1:0]          resp_valid,
  output logic [NUM_PROC*DATA_W-1:0]   resp_data,
  output logic [NUM_BANK-1:0]          bank_en,
  output logic [NUM_BANK-1:0]          bank_we,
  output logic [NUM_BANK*IDX_W-1:0]    bank_idx,
  output logic [NUM_BANK*DATA_W-1:0]   bank_wdata,
  input  logic [NUM_BANK*DATA_W-1:0]   bank_rdata
);
  logic [NUM_PROC-1:0][ADDR_W-1:0]   addr_arr;
  logic [NUM_PROC-1:0][DATA_W-1:0]   wdata_arr;
  logic [NUM_PROC-1:0][BANK_W-1:0]   bank_sel;
  logic [NUM_PROC-1:0][TAG_W-1:0]    blk_tag;
  logic [NUM_BANK-1:0][NUM_PROC-1:0] gnt_bank;
  logic [NUM_PROC-1:0][NUM_BANK-1:0] hits;
  logic [NUM_PROC-1:0]               served;
  logic [NUM_BANK-1:0][IDX_W-1:0]    idx_arr;
  logic [NUM_BANK-1:0][DATA_W-1:0]   bwd_arr;
  logic [NUM_BANK-1:0][DATA_W-1:0]   brd_arr;
  logic [NUM_PROC-1:0][DATA_W-1:0]   rsp_arr;

  assign addr_arr   = req_addr;
  assign wdata_arr  = req_wdata;
  assign brd_arr    = bank_rdata;
  assign bank_idx   = idx_arr;
  assign bank_wdata = bwd_arr;
  assign resp_data  = rsp_arr;

  xbar_req_decode #(
    .NUM_PROC (NUM_PROC),
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .BANK_W   (BANK_W)
  ) u_decode (
    .addr     (addr_arr),
    .bank_sel (bank_sel),
    .blk_tag  (blk_tag)
  );

  generate
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      xbar_bank_slice #(
        .NUM_PROC (NUM_PROC),
        .BANK_W   (BANK_W),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W),
        .BANK_ID  (b)
      ) u_slice (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .bank_sel  (bank_sel),
        .blk_tag   (blk_tag),
        .wdata     (wdata_arr),
        .grant     (gnt_bank[b]),
        .mem_en    (bank_en[b]),
        .mem_we    (bank_we[b]),
        .mem_idx   (idx_arr[b]),
        .mem_wdata (bwd_arr[b])
      );
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < NUM_PROC; p++) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        hits[p][b] = gnt_bank[b][p];
      end
      served[p] = |hits[p];
    end
  end

  assign req_stall = req_valid & ~served;

  xbar_resp_route #(
    .NUM_PROC (NUM_PROC),
    .NUM_BANK (NUM_BANK),
    .BANK_W   (BANK_W),
    .DATA_W   (DATA_W)
  ) u_resp (
    .clk        (clk),
    .rst        (rst),
    .rd_served  (served & ~req_write),
    .bank_sel   (bank_sel),
    .bank_rdata (brd_arr),
    .resp_valid (resp_valid),
    .resp_data  (rsp_arr)
  );

  generate
    for (genvar p = 0; p < NUM_PROC; p++) begin : g_chk
      AST_ONE_BANK_PER_PROC: assert property (@(posedge clk) disable iff (rst)
        ($countones(hits[p]) <= 1)); // R1

      AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        resp_valid[p] |-> $past(req_valid[p] && !req_stall[p] && !req_write[p])); // R6

      AST_READ_GETS_RESP: assert property (@(posedge clk) disable iff (rst)
        (req_valid[p] && !req_stall[p] && !req_write[p]) |=> resp_valid[p]); // R6
    end
  endgenerate

endmodule

// File: tb/tb_xbar_bank_arb.sv
module tb_xbar_bank_arb;
  localparam int N      = 4;
  localparam int M      = 8;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 2;
  localparam int DATA_W = 32;
  localparam int BANK_W = $clog2(M);
  localparam int IDX_W  = ADDR_W - OFF_W - BANK_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0]            v_in, w_in;
  logic [ADDR_W-1:0]       a_in [N];
  logic [DATA_W-1:0]       d_in [N];
  logic [N*ADDR_W-1:0]     req_addr;
  logic [N*DATA_W-1:0]     req_wdata;
  logic [N-1:0]            req_stall, resp_valid;
  logic [N*DATA_W-1:0]     resp_data;
  logic [M-1:0]            bank_en, bank_we;
  logic [M*IDX_W-1:0]      bank_idx;
  logic [M*DATA_W-1:0]     bank_wdata;
  logic [M*DATA_W-1:0]     bank_rdata;

  generate
    for (genvar p = 0; p < N; p++) begin : g_pack
      assign req_addr[p*ADDR_W +: ADDR_W]  = a_in[p];
      assign req_wdata[p*DATA_W +: DATA_W] = d_in[p];
    end
  endgenerate

  xbar_bank_arb #(
    .NUM_PROC (N), .NUM_BANK (M), .ADDR_W (ADDR_W), .OFF_W (OFF_W), .DATA_W (DATA_W)
  ) dut (
    .clk (clk), .rst (rst),
    .req_valid (v_in), .req_write (w_in), .req_addr (req_addr), .req_wdata (req_wdata),
    .req_stall (req_stall), .resp_valid (resp_valid), .resp_data (resp_data),
    .bank_en (bank_en), .bank_we (bank_we), .bank_idx (bank_idx),
    .bank_wdata (bank_wdata), .bank_rdata (bank_rdata)
  );

  function automatic logic [DATA_W-1:0] seed_word(input int b, input int i);
    return DATA_W'(32'hA5000000 ^ (b << 12) ^ (i * 7));
  endfunction

  // Bench-side synchronous bank memories.
  logic [DATA_W-1:0] bmem [M][DEPTH];
  always_ff @(posedge clk) begin
    for (int b = 0; b < M; b++) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) bmem[b][i] <= seed_word(b, i);
        bank_rdata[b*DATA_W +: DATA_W] <= '0;
      end else if (bank_en[b]) begin
        if (bank_we[b]) bmem[b][bank_idx[b*IDX_W +: IDX_W]] <= bank_wdata[b*DATA_W +: DATA_W];
        else bank_rdata[b*DATA_W +: DATA_W] <= bmem[b][bank_idx[b*IDX_W +: IDX_W]];
      end
    end
  end

  // Reference model state.
  logic [DATA_W-1:0] ref_mem [M][DEPTH];
  int                ptr_m [M];
  logic [N-1:0]      exp_rv;
  logic [DATA_W-1:0] exp_rd [N];
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [ADDR_W-1:0] a);
    return int'(a[OFF_W +: BANK_W]);
  endfunction
  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'(a[ADDR_W-1:OFF_W+BANK_W]);
  endfunction
  function automatic logic [ADDR_W-1:0] mk_addr(input int b, input int i, input int off);
    return {IDX_W'(i), BANK_W'(b), OFF_W'(off)};
  endfunction

  // One cycle: check last responses, drive, check stalls, advance the model.
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] w,
                      input logic [ADDR_W-1:0] a [N], input logic [DATA_W-1:0] d [N]);
    logic [N-1:0] eg;
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      check(resp_valid[p] == exp_rv[p], $sformatf("R6 resp_valid p%0d", p), 64'(resp_valid[p]), 64'(exp_rv[p]));
      if (exp_rv[p])
        check(resp_data[p*DATA_W +: DATA_W] == exp_rd[p], $sformatf("R6 resp_data p%0d", p),
              64'(resp_data[p*DATA_W +: DATA_W]), 64'(exp_rd[p]));
    end
    v_in = v; w_in = w;
    for (int p = 0; p < N; p++) begin a_in[p] = a[p]; d_in[p] = d[p]; end
    #1;
    eg = '0;
    for (int b = 0; b < M; b++) begin
      int win;
      win = -1;
      for (int i = 0; i < N; i++) begin
        int k;
        k = (ptr_m[b] + i) % N;
        if (win < 0 && v[k] && bank_of(a[k]) == b) win = k;
      end
      check(bank_en[b] == (win >= 0), $sformatf("R3 bank_en b%0d", b), 64'(bank_en[b]), 64'(win >= 0));
      if (win >= 0) begin
        for (int p = 0; p < N; p++) begin
          if (v[p] && bank_of(a[p]) == b &&
              (p == win || (!w[win] && !w[p] && a[p][ADDR_W-1:OFF_W] == a[win][ADDR_W-1:OFF_W])))
            eg[p] = 1'b1;
        end
        if (w[win]) ref_mem[b][idx_of(a[win])] = d[win];
        ptr_m[b] = (win + 1) % N;
      end
    end
    for (int p = 0; p < N; p++) begin
      check(req_stall[p] == (v[p] && !eg[p]),
            $sformatf("stall p%0d (R1 R2 R3 R4 R5 R7)", p), 64'(req_stall[p]), 64'(v[p] && !eg[p]));
      exp_rv[p] = eg[p] && !w[p];
      if (exp_rv[p]) exp_rd[p] = ref_mem[bank_of(a[p])][idx_of(a[p])];
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a [N];
    logic [DATA_W-1:0] d [N];
    void'($urandom(32'd20240611));
    v_in = '0; w_in = '0;
    for (int p = 0; p < N; p++) begin a_in[p] = '0; d_in[p] = '0; end
    for (int b = 0; b < M; b++) begin
      ptr_m[b] = 0;
      for (int i = 0; i < DEPTH; i++) ref_mem[b][i] = seed_word(b, i);
    end
    exp_rv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resp_valid == '0, "R8 resp_valid in reset", 64'(resp_valid), 64'(0));
    rst = 1'b0;

    // R8: pointers start at processor 0; p1 and p3 share bank 6 with different blocks, p1 wins.
    for (int p = 0; p < N; p++) begin a[p] = '0; d[p] = '0; end
    a[1] = mk_addr(6, 3, 0); a[3] = mk_addr(6, 9, 1);
    step(4'b1010, 4'b0000, a, d);
    check(req_stall == 4'b1000, "R8 R4 first winner after reset", 64'(req_stall), 64'(4'b1000));

    // R2: four distinct banks, none stalls.
    for (int p = 0; p < N; p++) a[p] = mk_addr(p + 4, p, p);
    step(4'b1111, 4'b0000, a, d);
    check(req_stall == '0, "R2 distinct banks", 64'(req_stall), 64'(0));

    // R5: all four read one block, merged.
    for (int p = 0; p < N; p++) a[p] = mk_addr(5, 2, p);
    step(4'b1111, 4'b0000, a, d);
    check(req_stall == '0, "R5 merged read", 64'(req_stall), 64'(0));

    // R7: write to a block while others read it; only one request passes.
    for (int p = 0; p < N; p++) begin a[p] = mk_addr(1, 0, 0); d[p] = 32'hC0DE0000 + p; end
    step(4'b1111, 4'b0001, a, d);
    check($countones(~req_stall) == 1, "R7 exclusive", 64'($countones(~req_stall)), 64'(1));
    // R7: read back the written word.
    step(4'b0010, 4'b0000, a, d);

    // R4: two different blocks in bank 2, alternating winners.
    a[0] = mk_addr(2, 1, 0); a[1] = mk_addr(2, 5, 0);
    for (int r = 0; r < 4; r++) step(4'b0011, 4'b0000, a, d);

    // R3: idle cycle, no stall.
    step(4'b0000, 4'b0000, a, d);
    check(req_stall == '0, "R3 idle", 64'(req_stall), 64'(0));

    // Random traffic crowded onto few banks and blocks.
    for (int t = 0; t < 3000; t++) begin
      logic [N-1:0] v, w;
      for (int p = 0; p < N; p++) begin
        int b;
        v[p] = ($urandom % 5) != 0;
        w[p] = ($urandom % 4) == 0;
        b = (($urandom % 2) == 0) ? int'($urandom % 2) : int'($urandom % M);
        a[p] = mk_addr(b, int'($urandom % 4), int'($urandom % 4));
        d[p] = $urandom;
      end
      step(v, w, a, d);
    end
    step('0, '0, a, d);
    step('0, '0, a, d);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule